// File: doc/BRIEF.md
# Peripheral Frame Write-Protection Controller

This block keeps one write-protection bit for each of 64 peripheral memory frames and exposes that state on a small register bus. Each 32-frame half of the state is reached through two aliases. One alias sets bits and the other clears them, and both use write-one semantics. Only privileged bus writes change the state. Bit positions that have no peripheral behind them, as given by a 64-bit mask parameter, are not stored and always read as zero.

The same state drives an access checker. The checker takes a frame index, a privilege flag and a read/write flag, and it answers in the same cycle with a grant or a deny. A protected frame stays readable in both modes, but it can be written only by privileged accesses. A user write to a protected frame is denied. One cycle later that denied write raises a single-cycle violation pulse.

Top module: `frame_wprot_ctrl`

## Requirements
- R1: After reset every protection bit is 0, and all four aliases (set low 0x00, set high 0x04, clear low 0x10, clear high 0x14) read 0.
- R2: A privileged write to the clear alias (0x10 for frames 0–31, 0x14 for frames 32–63, data bit n mapping to frame 32*half+n) clears each bit written as 1. Bits written as 0 are left unchanged.
- R3: A privileged write to the set alias (0x00 low, 0x04 high) sets each bit written as 1. Bits written as 0 are left unchanged.
- R4: The set alias and the clear alias of a half read back the same current protection state.
- R5: A bus write with cfg_priv_i low changes no state, and cfg_err_o is high in the same cycle.
- R6: A position whose bit in IMPL_MASK is 0 ignores every write and always reads 0.
- R7: An access to a frame whose bit is 0 is granted for all four combinations of privilege and direction.
- R8: For a frame whose bit is 1, reads are granted in both modes and privileged writes are granted. A user write gets acc_deny_o high and acc_grant_o low.
- R9: acc_viol_o is high in the cycle after each denied request and low after any cycle with no denied request.
- R10: An address other than the four aliases reads 0. A write to it sets cfg_err_o and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_addr_i | input | 5 | Register byte offset |
| cfg_wdata_i | input | 32 | Write data |
| cfg_we_i | input | 1 | Write strobe |
| cfg_priv_i | input | 1 | Bus access is privileged |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i (combinational) |
| cfg_err_o | output | 1 | Write ignored (user mode or bad offset) |
| acc_req_i | input | 1 | Frame access request valid |
| acc_frame_i | input | 6 | Frame index |
| acc_priv_i | input | 1 | Access is privileged |
| acc_write_i | input | 1 | Access is a write |
| acc_grant_o | output | 1 | Access allowed (passed downstream) |
| acc_deny_o | output | 1 | Access blocked |
| acc_viol_o | output | 1 | Registered violation pulse |

## Verification
On every cycle, the assertions check that user and bad-offset writes leave the state unchanged, that set and clear writes take effect in the next cycle, that unimplemented positions stay zero, that no user write to a protected frame is granted, and that every violation pulse follows a denied user write. The bench scenarios are what show the bit-to-frame mapping in each half, that the two aliases read back the same state, the exact read data of partly implemented words, and the full privilege/direction matrix for all 64 frames under a sparse mask.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 5;
  localparam logic [4:0]  SET_BASE = 5'h00;
  localparam logic [4:0]  CLR_BASE = 5'h10;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_SET,
    REG_CLR
  } reg_kind_e;
endpackage

// File: rtl/fwp_regbank.sv
module fwp_regbank
  import fwp_pkg::*;
#(
  parameter int unsigned      NUM_FRAMES = 64,
  parameter logic [NUM_FRAMES-1:0] IMPL_MASK = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [WORD_W-1:0]     wdata_i,
  input  logic                  we_i,
  input  logic                  priv_i,
  output logic [WORD_W-1:0]     rdata_o,
  output logic                  err_o,
  output logic [NUM_FRAMES-1:0] prot_o
);
  localparam int unsigned NWORDS = NUM_FRAMES / WORD_W;
  localparam int unsigned IDX_W  = 2;

  logic [NUM_FRAMES-1:0] prot_q, prot_d, set_v, clr_v;
  logic [IDX_W-1:0]      idx;
  reg_kind_e             kind;
  logic                  wen;

  assign idx = addr_i[3:2];

  always_comb begin
    kind = REG_NONE;
    if (addr_i[1:0] == 2'b00 && 32'(idx) < NWORDS)
      kind = addr_i[4] ? REG_CLR : REG_SET;
  end

  assign wen = we_i && priv_i && (kind != REG_NONE);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic hit;
    assign hit = wen && (32'(idx) == w);
    assign set_v[w*WORD_W +: WORD_W] = (hit && kind == REG_SET) ? wdata_i : '0;
    assign clr_v[w*WORD_W +: WORD_W] = (hit && kind == REG_CLR) ? wdata_i : '0;
  end

  // clear wins over set on the same bit
  assign prot_d = (prot_q | set_v) & ~clr_v & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prot_q <= '0;
    else         prot_q <= prot_d;
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NWORDS; w++)
      if (kind != REG_NONE && 32'(idx) == w) rdata_o = prot_q[w*WORD_W +: WORD_W];
  end

  assign err_o  = we_i && (!priv_i || kind == REG_NONE);
  assign prot_o = prot_q;

  a_r5_user_write_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i) |=> $stable(prot_q));

  a_r10_bad_addr_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind == REG_NONE) |=> $stable(prot_q));

  a_r6_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_q & ~IMPL_MASK) == '0);

  a_r3_set_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && priv_i && kind == REG_SET && idx == 2'd0)
      |=> ((prot_q[WORD_W-1:0] & $past(wdata_i) & IMPL_MASK[WORD_W-1:0])
           == ($past(wdata_i) & IMPL_MASK[WORD_W-1:0])));

  a_r2_clr_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && priv_i && kind == REG_CLR && idx == 2'd0)
      |=> ((prot_q[WORD_W-1:0] & $past(wdata_i)) == '0));
endmodule

// File: rtl/fwp_access_chk.sv
module fwp_access_chk #(
  parameter int unsigned NUM_FRAMES = 64,
  localparam int unsigned FR_W      = $clog2(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FRAMES-1:0] prot_i,
  input  logic                  req_i,
  input  logic [FR_W-1:0]       frame_i,
  input  logic                  priv_i,
  input  logic                  write_i,
  output logic                  grant_o,
  output logic                  deny_o,
  output logic                  viol_o
);
  logic locked, blocked, viol_q;

  assign locked  = prot_i[frame_i];
  assign blocked = write_i && !priv_i && locked;
  assign grant_o = req_i && !blocked;
  assign deny_o  = req_i && blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= deny_o;
  end
  assign viol_o = viol_q;

  a_r8_no_user_write_to_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && write_i && !priv_i && prot_i[frame_i]) |-> !grant_o);

  a_r7_free_frame_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !prot_i[frame_i]) |-> grant_o);

  a_r9_viol_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(req_i && write_i && !priv_i));

  a_r8_grant_deny_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && deny_o));
endmodule

// File: rtl/frame_wprot_ctrl.sv
module frame_wprot_ctrl
  import fwp_pkg::*;
#(
  parameter int unsigned           NUM_FRAMES = 64,
  parameter logic [NUM_FRAMES-1:0] IMPL_MASK  = '1,
  localparam int unsigned          FR_W       = $clog2(NUM_FRAMES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              cfg_we_i,
  input  logic              cfg_priv_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              cfg_err_o,
  input  logic              acc_req_i,
  input  logic [FR_W-1:0]   acc_frame_i,
  input  logic              acc_priv_i,
  input  logic              acc_write_i,
  output logic              acc_grant_o,
  output logic              acc_deny_o,
  output logic              acc_viol_o
);
  logic [NUM_FRAMES-1:0] prot;

  fwp_regbank #(.NUM_FRAMES(NUM_FRAMES), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .we_i    (cfg_we_i),
    .priv_i  (cfg_priv_i),
    .rdata_o (cfg_rdata_o),
    .err_o   (cfg_err_o),
    .prot_o  (prot)
  );

  fwp_access_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prot_i  (prot),
    .req_i   (acc_req_i),
    .frame_i (acc_frame_i),
    .priv_i  (acc_priv_i),
    .write_i (acc_write_i),
    .grant_o (acc_grant_o),
    .deny_o  (acc_deny_o),
    .viol_o  (acc_viol_o)
  );
endmodule

// File: tb/frame_wprot_ctrl_bench.sv
module frame_wprot_ctrl_bench;
  localparam logic [63:0] MASK = 64'hFFFF_0FF0_7FFF_FFFE;

  logic        clk = 0, rst_n = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 0, priv = 0;
  logic [31:0] rdata;
  logic        err;
  logic        req = 0, apriv = 0, awr = 0;
  logic [5:0]  frame = '0;
  logic        grant, deny, viol;

  int n_chk = 0, n_bad = 0;
  logic [63:0] model = '0;

  always #10 clk = ~clk;

  frame_wprot_ctrl #(.NUM_FRAMES(64), .IMPL_MASK(MASK)) u_frame_wprot_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_we_i(we), .cfg_priv_i(priv), .cfg_rdata_o(rdata), .cfg_err_o(err),
    .acc_req_i(req), .acc_frame_i(frame), .acc_priv_i(apriv), .acc_write_i(awr),
    .acc_grant_o(grant), .acc_deny_o(deny), .acc_viol_o(viol)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; we = 0;
    #1 chk(rdata, exp, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic p, input string tag);
    logic bad_addr;
    bad_addr = !(a == 5'h00 || a == 5'h04 || a == 5'h10 || a == 5'h14);
    @(negedge clk);
    addr = a; wdata = d; priv = p; we = 1;
    #1 chk({31'd0, err}, {31'd0, (!p || bad_addr)}, tag);
    @(posedge clk);
    if (p && !bad_addr) begin
      if (a[4]) model = model & ~({32'd0, d} << (a[2] ? 32 : 0));
      else      model = (model | ({32'd0, d} << (a[2] ? 32 : 0))) & MASK;
    end
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd_all(input string tag);
    rd(5'h00, model[31:0],  {tag, " R4 set lo"});
    rd(5'h10, model[31:0],  {tag, " R4 clr lo"});
    rd(5'h04, model[63:32], {tag, " R4 set hi"});
    rd(5'h14, model[63:32], {tag, " R4 clr hi"});
  endtask

  task automatic acc(input int f, input logic p, input logic w, input string tag);
    logic exp_g;
    @(negedge clk);
    req = 1; frame = 6'(f); apriv = p; awr = w;
    exp_g = !(w && !p && model[f]);
    #1;
    chk({30'd0, grant, deny}, {30'd0, exp_g, !exp_g}, tag);
    @(negedge clk);
    chk({31'd0, viol}, {31'd0, !exp_g}, {tag, " R9 pulse"});
    req = 0;
    @(negedge clk);
    chk({31'd0, viol}, 32'd0, {tag, " R9 drop"});
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_all("R1 reset");

    // whole-word patterns
    wr(5'h00, 32'hFFFF_FFFF, 1, "R3 set all lo");
    wr(5'h04, 32'hFFFF_FFFF, 1, "R3 set all hi");
    rd_all("R6 mask readback");
    wr(5'h10, 32'h0000_0000, 1, "R2 clr zero");
    rd_all("R2 zero no change");
    wr(5'h10, 32'hFFFF_FFFF, 0, "R5 user clr");
    wr(5'h04, 32'h0000_0000, 0, "R5 user set");
    rd_all("R5 unchanged");
    wr(5'h08, 32'hFFFF_FFFF, 1, "R10 bad set");
    wr(5'h18, 32'hFFFF_FFFF, 1, "R10 bad clr");
    wr(5'h01, 32'hFFFF_FFFF, 1, "R10 misaligned");
    rd(5'h08, 32'd0, "R10 bad read");
    rd(5'h1C, 32'd0, "R10 bad read2");
    rd_all("R10 unchanged");
    wr(5'h10, 32'hA5A5_A5A5, 1, "R2 clr pattern lo");
    wr(5'h14, 32'h0F0F_0F0F, 1, "R2 clr pattern hi");
    rd_all("R2 pattern");
    wr(5'h00, 32'h5A5A_5A5A, 1, "R3 set pattern lo");
    rd_all("R3 pattern");
    wr(5'h10, 32'hFFFF_FFFF, 1, "R2 clr lo");
    wr(5'h14, 32'hFFFF_FFFF, 1, "R2 clr hi");
    rd_all("R2 cleared");

    // per-frame sweep
    for (int f = 0; f < 64; f++) begin
      logic [4:0] sa, ca;
      logic [31:0] b;
      sa = (f < 32) ? 5'h00 : 5'h04;
      ca = (f < 32) ? 5'h10 : 5'h14;
      b  = 32'd1 << (f % 32);
      for (int m = 0; m < 4; m++) acc(f, m[0], m[1], $sformatf("R7 free f%0d m%0d", f, m));
      wr(ca == 5'h10 ? 5'h00 : 5'h04, b, 0, $sformatf("R5 user set f%0d", f));
      rd(sa, (f < 32) ? model[31:0] : model[63:32], $sformatf("R5 f%0d", f));
      wr(sa, b, 1, $sformatf("R3 set f%0d", f));
      rd(sa, (f < 32) ? model[31:0] : model[63:32], $sformatf("R6 R3 f%0d set", f));
      rd(ca, (f < 32) ? model[31:0] : model[63:32], $sformatf("R4 f%0d clr view", f));
      for (int m = 0; m < 4; m++) acc(f, m[0], m[1], $sformatf("R8 f%0d m%0d", f, m));
      wr(ca, b, 0, $sformatf("R5 user clr f%0d", f));
      rd(ca, (f < 32) ? model[31:0] : model[63:32], $sformatf("R5 f%0d kept", f));
      wr(ca, b, 1, $sformatf("R2 clr f%0d", f));
      rd(sa, (f < 32) ? model[31:0] : model[63:32], $sformatf("R2 f%0d cleared", f));
    end

    // back-to-back denied writes keep the pulse high
    wr(5'h04, 32'h8000_0000, 1, "R3 set f63");
    @(negedge clk);
    req = 1; frame = 6'd63; apriv = 0; awr = 1;
    @(negedge clk);
    chk({31'd0, viol}, 32'd1, "R9 b2b 1");
    @(negedge clk);
    chk({31'd0, viol}, 32'd1, "R9 b2b 2");
    awr = 0;
    @(negedge clk);
    chk({31'd0, viol}, 32'd0, "R9 read no pulse");
    req = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule